// File: doc/BRIEF.md
# Privileged Interface-Select Control Register

This block holds the 64-bit control register that the highest privilege level (level 3) uses to choose how the interrupt controller's CPU-interface registers are reached. They can be reached through system-register instructions or through a memory-mapped path. The block decodes a five-field system-register encoding together with the current privilege level. Level-3 reads return the register in the same cycle, and level-3 writes update it at the next clock edge. Accesses from lower levels produce a one-cycle undefined-instruction pulse.

The register drives four controls: the interface-select bit, the FIQ bypass disable, the IRQ bypass disable, and an enable bit that lets lower levels reach their own select registers. The block also reports trap decisions in the same cycle as the request. These cover level-1 and level-2 accesses to the lower-level select registers, and level-3 accesses to other interrupt-interface registers while the memory-mapped path is selected. Build-time parameters can hardwire individual fields to read as one and ignore writes.

The interface-select bit is held by a two-state machine. In state ST_MEMMAP the bit is 0, and in state ST_SYSREG the bit is 1. Transition TR_ENABLE_SYS goes from ST_MEMMAP to ST_SYSREG on a level-3 write with bit 0 set. Transition TR_REVERT goes from ST_SYSREG to ST_MEMMAP on a level-3 write with bit 0 clear, and it raises the unpredictable flag. Every other cycle keeps the current state. When the select bit is hardwired, the machine resets into ST_SYSREG and never leaves it.

Top module: `psel_ctrl`

## Requirements
- R1: Only the encoding op0=0b11, op1=0b110, CRn=0b1100, CRm=0b1100, op2=0b101 addresses the register. Any other encoding gives no undefined pulse, a read value of zero and no change to the register.
- R2: A matching access at level 0, 1 or 2 raises `acc_undef` in the request cycle, reads as zero and leaves the register unchanged.
- R3: A level-3 read returns the select bit in bit 0, the FIQ bypass disable in bit 1, the IRQ bypass disable in bit 2 and the enable in bit 3. A level-3 write stores these bits from `acc_wdata`, and the new value is visible from the next cycle.
- R4: Bits 63:4 always read as zero, and writes to them are ignored.
- R5: After reset the select bit, FIQ bypass disable and IRQ bypass disable read 0.
- R6: While the select bit is 0, `other_valid` raises `other_trap` in the same cycle. While the select bit is 1, `other_trap` stays low.
- R7: A level-1 access (`low_el`=1) to the level-1 select register (`low_target`=0) raises `trap_el2` when `el2_enable` is 0. Otherwise it raises `trap_el3` when the effective enable is 0. At most one of the two is high.
- R8: A level-2 access (`low_el`=2) to either lower select register raises `trap_el3` when the effective enable is 0. Accesses at levels 0 and 3, and level-1 accesses with `low_target`=1, raise no trap.
- R9: The effective enable is the stored enable OR the inverted select bit. With the select bit at 0 no `trap_el3` occurs, yet the enable still reads back as stored.
- R10: With FIQ_BYP_PRESENT=0 bit 1 reads 1 and ignores writes, and with IRQ_BYP_PRESENT=0 bit 2 does the same.
- R11: With SEL_FIXED_ONE=1 bit 0 reads 1 and ignores writes. With EN_FIXED_ONE=1 as well, bit 3 also reads 1 and ignores writes.
- R12: A level-3 write with bit 0 clear while the select bit is 1 (TR_REVERT) pulses `wr_unpredictable` in the request cycle, and the value is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_op0 | input | 2 | Encoding field op0 |
| acc_op1 | input | 3 | Encoding field op1 |
| acc_crn | input | 4 | Encoding field CRn |
| acc_crm | input | 4 | Encoding field CRm |
| acc_op2 | input | 3 | Encoding field op2 |
| acc_el | input | 2 | Privilege level of the request |
| acc_wdata | input | DATA_W | Write data |
| acc_rdata | output | DATA_W | Read data, zero unless a level-3 read hits |
| acc_undef | output | 1 | Undefined-instruction pulse |
| wr_unpredictable | output | 1 | Select bit cleared from 1 by this write |
| low_valid | input | 1 | Lower-level access to a lower select register |
| low_el | input | 2 | Level of that access |
| low_target | input | 1 | 0 = level-1 select register, 1 = level-2 select register |
| el2_enable | input | 1 | Enable bit of the level-2 select register |
| other_valid | input | 1 | Level-3 access to another interrupt-interface register |
| trap_el2 | output | 1 | Lower access traps to level 2 |
| trap_el3 | output | 1 | Lower access traps to level 3 |
| other_trap | output | 1 | Other-register access traps to level 3 |
| iface_sel | output | 1 | Interface-select bit (1 = system registers) |
| fiq_byp_dis | output | 1 | FIQ bypass disable |
| irq_byp_dis | output | 1 | IRQ bypass disable |
| lower_enable | output | 1 | Stored enable bit |

## Verification
The hardest situations to reach combine register state with a trap query. One is the enable stored as 0 while the select bit is also 0, where the stored value must read back and yet cause no level-3 trap. The other is the TR_REVERT write, which needs the select bit first set to 1. The bench writes all sixteen values of the low nibble in ascending order, so every odd-to-even step exercises TR_REVERT. After each write it sweeps every combination of lower level, target register and level-2 enable against an arithmetic model. A second instance with all fields hardwired receives the same stimulus.

// File: rtl/psel_pkg.sv
package psel_pkg;

    localparam int CTRL_W = 4;

    localparam int POS_SEL = 0;
    localparam int POS_FIQ = 1;
    localparam int POS_IRQ = 2;
    localparam int POS_EN  = 3;

    localparam logic [1:0] LVL_TOP = 2'd3;
    localparam logic [1:0] LVL_MID = 2'd2;
    localparam logic [1:0] LVL_LOW = 2'd1;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sysreg_enc_t;

    localparam sysreg_enc_t PSEL_ENC = '{op0: 2'b11, op1: 3'b110, crn: 4'b1100,
                                         crm: 4'b1100, op2: 3'b101};

    typedef enum logic [0:0] {
        ST_MEMMAP = 1'b0,
        ST_SYSREG = 1'b1
    } psel_state_e;

endpackage

// File: rtl/psel_decode.sv
module psel_decode
    import psel_pkg::*;
(
    input  logic        req_valid,
    input  logic        req_write,
    input  sysreg_enc_t req_enc,
    input  logic [1:0]  req_el,
    output logic        rd_ok,
    output logic        wr_ok,
    output logic        undef
);
    logic hit;
    logic top_lvl;

    always_comb begin
        hit     = req_valid && (req_enc == PSEL_ENC);
        top_lvl = (req_el == LVL_TOP);
        rd_ok   = hit && top_lvl && !req_write;
        wr_ok   = hit && top_lvl && req_write;
        undef   = hit && !top_lvl;
    end
endmodule

// File: rtl/psel_trap.sv
module psel_trap
    import psel_pkg::*;
(
    input  logic       sel_bit,
    input  logic       en_bit,
    input  logic       low_valid,
    input  logic [1:0] low_el,
    input  logic       low_target,
    input  logic       el2_enable,
    input  logic       other_valid,
    output logic       trap_el2,
    output logic       trap_el3,
    output logic       other_trap
);
    logic eff_en;
    logic from_low;
    logic from_mid;

    always_comb begin
        eff_en     = en_bit || !sel_bit;
        from_low   = low_valid && (low_el == LVL_LOW) && !low_target;
        from_mid   = low_valid && (low_el == LVL_MID);
        trap_el2   = from_low && !el2_enable;
        trap_el3   = !eff_en && ((from_low && el2_enable) || from_mid);
        other_trap = other_valid && !sel_bit;
    end
endmodule

// File: rtl/psel_ctrl.sv
module psel_ctrl
    import psel_pkg::*;
#(
    parameter int DATA_W          = 64,
    parameter bit SEL_FIXED_ONE   = 1'b0,
    parameter bit EN_FIXED_ONE    = 1'b0,
    parameter bit FIQ_BYP_PRESENT = 1'b1,
    parameter bit IRQ_BYP_PRESENT = 1'b1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_op0,
    input  logic [2:0]        acc_op1,
    input  logic [3:0]        acc_crn,
    input  logic [3:0]        acc_crm,
    input  logic [2:0]        acc_op2,
    input  logic [1:0]        acc_el,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              acc_undef,
    output logic              wr_unpredictable,
    input  logic              low_valid,
    input  logic [1:0]        low_el,
    input  logic              low_target,
    input  logic              el2_enable,
    input  logic              other_valid,
    output logic              trap_el2,
    output logic              trap_el3,
    output logic              other_trap,
    output logic              iface_sel,
    output logic              fiq_byp_dis,
    output logic              irq_byp_dis,
    output logic              lower_enable
);
    localparam int          RSVD_W  = DATA_W - CTRL_W;
    localparam bit          EN_HARD = SEL_FIXED_ONE && EN_FIXED_ONE;
    localparam psel_state_e RST_ST  = SEL_FIXED_ONE ? ST_SYSREG : ST_MEMMAP;

    sysreg_enc_t enc;
    logic        rd_ok;
    logic        wr_ok;
    logic        sel_bit;
    logic        fiq_q;
    logic        irq_q;
    logic        en_q;
    psel_state_e state_q;
    psel_state_e state_d;

    assign enc = '{op0: acc_op0, op1: acc_op1, crn: acc_crn, crm: acc_crm, op2: acc_op2};

    psel_decode u_decode (
        .req_valid (acc_valid),
        .req_write (acc_write),
        .req_enc   (enc),
        .req_el    (acc_el),
        .rd_ok     (rd_ok),
        .wr_ok     (wr_ok),
        .undef     (acc_undef)
    );

    // State register for the interface-select bit
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RST_ST;
        else        state_q <= state_d;
    end

    // Next state: TR_ENABLE_SYS and TR_REVERT
    always_comb begin
        state_d = state_q;
        if (!SEL_FIXED_ONE) begin
            unique case (state_q)
                ST_MEMMAP: if (wr_ok &&  acc_wdata[POS_SEL]) state_d = ST_SYSREG;
                ST_SYSREG: if (wr_ok && !acc_wdata[POS_SEL]) state_d = ST_MEMMAP;
                default:   state_d = ST_MEMMAP;
            endcase
        end
    end

    // Outputs of the state machine
    always_comb begin
        sel_bit          = (state_q == ST_SYSREG);
        wr_unpredictable = !SEL_FIXED_ONE && (state_q == ST_SYSREG) &&
                           wr_ok && !acc_wdata[POS_SEL];
    end

    generate
        if (FIQ_BYP_PRESENT) begin : g_fiq_rw
            always_ff @(posedge clk) begin
                if (!rst_n)     fiq_q <= 1'b0;
                else if (wr_ok) fiq_q <= acc_wdata[POS_FIQ];
            end
        end else begin : g_fiq_fixed
            assign fiq_q = 1'b1;
        end

        if (IRQ_BYP_PRESENT) begin : g_irq_rw
            always_ff @(posedge clk) begin
                if (!rst_n)     irq_q <= 1'b0;
                else if (wr_ok) irq_q <= acc_wdata[POS_IRQ];
            end
        end else begin : g_irq_fixed
            assign irq_q = 1'b1;
        end

        if (!EN_HARD) begin : g_en_rw
            always_ff @(posedge clk) begin
                if (!rst_n)     en_q <= 1'b0;
                else if (wr_ok) en_q <= acc_wdata[POS_EN];
            end
        end else begin : g_en_fixed
            assign en_q = 1'b1;
        end
    endgenerate

    psel_trap u_trap (
        .sel_bit     (sel_bit),
        .en_bit      (en_q),
        .low_valid   (low_valid),
        .low_el      (low_el),
        .low_target  (low_target),
        .el2_enable  (el2_enable),
        .other_valid (other_valid),
        .trap_el2    (trap_el2),
        .trap_el3    (trap_el3),
        .other_trap  (other_trap)
    );

    always_comb begin
        acc_rdata    = rd_ok ? {{RSVD_W{1'b0}}, en_q, irq_q, fiq_q, sel_bit} : '0;
        iface_sel    = sel_bit;
        fiq_byp_dis  = fiq_q;
        irq_byp_dis  = irq_q;
        lower_enable = en_q;
    end
endmodule

// File: rtl/psel_ctrl_chk.sv
module psel_ctrl_chk
    import psel_pkg::*;
#(
    parameter int DATA_W = 64
)(
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [1:0]        acc_op0,
    input logic [2:0]        acc_op1,
    input logic [3:0]        acc_crn,
    input logic [3:0]        acc_crm,
    input logic [2:0]        acc_op2,
    input logic [1:0]        acc_el,
    input logic [DATA_W-1:0] acc_rdata,
    input logic              acc_undef,
    input logic              wr_unpredictable,
    input logic              other_valid,
    input logic              trap_el2,
    input logic              trap_el3,
    input logic              other_trap,
    input logic              iface_sel,
    input logic              fiq_byp_dis,
    input logic              irq_byp_dis,
    input logic              lower_enable
);
    logic match;
    assign match = (acc_op0 == 2'b11) && (acc_op1 == 3'b110) && (acc_crn == 4'b1100) &&
                   (acc_crm == 4'b1100) && (acc_op2 == 3'b101);

    p_miss_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !match |-> !acc_undef && (acc_rdata == '0));

    p_undef_low_el_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && match && (acc_el != 2'd3) |-> acc_undef);

    p_undef_keeps_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_undef |=> $stable({iface_sel, fiq_byp_dis, irq_byp_dis, lower_enable}));

    p_rsvd_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rdata[DATA_W-1:CTRL_W] == '0);

    p_sel_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        other_valid && !iface_sel |-> other_trap);

    p_no_sel_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        iface_sel |-> !other_trap);

    p_trap_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trap_el2, trap_el3}));

    p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !iface_sel |-> !trap_el3);

    p_unpred_store_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_unpredictable |=> !iface_sel);
endmodule

bind psel_ctrl psel_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .acc_valid        (acc_valid),
    .acc_op0          (acc_op0),
    .acc_op1          (acc_op1),
    .acc_crn          (acc_crn),
    .acc_crm          (acc_crm),
    .acc_op2          (acc_op2),
    .acc_el           (acc_el),
    .acc_rdata        (acc_rdata),
    .acc_undef        (acc_undef),
    .wr_unpredictable (wr_unpredictable),
    .other_valid      (other_valid),
    .trap_el2         (trap_el2),
    .trap_el3         (trap_el3),
    .other_trap       (other_trap),
    .iface_sel        (iface_sel),
    .fiq_byp_dis      (fiq_byp_dis),
    .irq_byp_dis      (irq_byp_dis),
    .lower_enable     (lower_enable)
);

// File: tb/tb_psel_ctrl.sv
module tb_psel_ctrl;
    localparam logic [15:0] MATCH = 16'b11_110_1100_1100_101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [15:0] enc = MATCH;
    logic [1:0]  acc_el = 2'd0;
    logic [63:0] acc_wdata = '0;
    logic        low_valid = 1'b0;
    logic [1:0]  low_el = 2'd0;
    logic        low_target = 1'b0;
    logic        el2_enable = 1'b1;
    logic        other_valid = 1'b0;

    logic [63:0] rdata, rdata_hw;
    logic        undef, undef_hw, unpred, unpred_hw;
    logic        t2, t3, ot, t2_hw, t3_hw, ot_hw;
    logic        sel, fiq, irq, en, sel_hw, fiq_hw, irq_hw, en_hw;

    int checks = 0;
    int errors = 0;

    logic [63:0] cap_rdata, cap_rdata_hw;
    logic        cap_undef, cap_unpred, cap_unpred_hw;

    always #4 clk = ~clk;

    psel_ctrl dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_op0(enc[15:14]), .acc_op1(enc[13:11]), .acc_crn(enc[10:7]),
        .acc_crm(enc[6:3]), .acc_op2(enc[2:0]), .acc_el(acc_el), .acc_wdata(acc_wdata),
        .acc_rdata(rdata), .acc_undef(undef), .wr_unpredictable(unpred),
        .low_valid(low_valid), .low_el(low_el), .low_target(low_target),
        .el2_enable(el2_enable), .other_valid(other_valid),
        .trap_el2(t2), .trap_el3(t3), .other_trap(ot),
        .iface_sel(sel), .fiq_byp_dis(fiq), .irq_byp_dis(irq), .lower_enable(en)
    );

    psel_ctrl #(.SEL_FIXED_ONE(1'b1), .EN_FIXED_ONE(1'b1),
                .FIQ_BYP_PRESENT(1'b0), .IRQ_BYP_PRESENT(1'b0)) dut_hw (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_op0(enc[15:14]), .acc_op1(enc[13:11]), .acc_crn(enc[10:7]),
        .acc_crm(enc[6:3]), .acc_op2(enc[2:0]), .acc_el(acc_el), .acc_wdata(acc_wdata),
        .acc_rdata(rdata_hw), .acc_undef(undef_hw), .wr_unpredictable(unpred_hw),
        .low_valid(low_valid), .low_el(low_el), .low_target(low_target),
        .el2_enable(el2_enable), .other_valid(other_valid),
        .trap_el2(t2_hw), .trap_el3(t3_hw), .other_trap(ot_hw),
        .iface_sel(sel_hw), .fiq_byp_dis(fiq_hw), .irq_byp_dis(irq_hw), .lower_enable(en_hw)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic [1:0] el, input logic wr, input logic [63:0] wd,
                          input logic [15:0] e);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_el = el; acc_wdata = wd; enc = e;
        #1;
        cap_rdata = rdata; cap_rdata_hw = rdata_hw; cap_undef = undef;
        cap_unpred = unpred; cap_unpred_hw = unpred_hw;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; enc = MATCH;
    endtask

    logic [3:0] model;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R5 reset values
        access(2'd3, 1'b0, '0, MATCH);
        check("R5 reset low bits", {61'd0, cap_rdata[2:0]}, 64'd0);
        check("R11 hw reset read", cap_rdata_hw, 64'hF);

        // R3 R4 R12 R10 R11 sweep of all nibble values
        model = {1'b0, 3'b000};
        model[3] = cap_rdata[3];
        for (int v = 0; v < 16; v++) begin
            access(2'd3, 1'b1, {60'hA5A5_5A5A_F0F0_0FF, v[3:0]}, MATCH);
            check("R12 unpredictable flag", {63'd0, cap_unpred},
                  {63'd0, model[0] & ~v[0]});
            check("R11 hw no unpredictable", {63'd0, cap_unpred_hw}, 64'd0);
            model = v[3:0];
            access(2'd3, 1'b0, '0, MATCH);
            check("R3 R4 readback", cap_rdata, {60'd0, model});
            check("R10 R11 hw readback", cap_rdata_hw, 64'hF);
        end

        // R6 R7 R8 R9 trap sweep for every stored value
        for (int v = 0; v < 16; v++) begin
            access(2'd3, 1'b1, {60'd0, v[3:0]}, MATCH);
            for (int l = 0; l < 4; l++) begin
                for (int tg = 0; tg < 2; tg++) begin
                    for (int e2 = 0; e2 < 2; e2++) begin
                        logic eff, fl, fm, x2, x3;
                        @(negedge clk);
                        low_valid = 1'b1; low_el = l[1:0]; low_target = tg[0];
                        el2_enable = e2[0]; other_valid = 1'b1;
                        #1;
                        eff = v[3] | ~v[0];
                        fl  = (l == 1) && (tg == 0);
                        fm  = (l == 2);
                        x2  = fl && (e2 == 0);
                        x3  = !eff && ((fl && e2 == 1) || fm);
                        check("R7 trap_el2", {63'd0, t2}, {63'd0, x2});
                        check("R7 R8 R9 trap_el3", {63'd0, t3}, {63'd0, x3});
                        check("R6 other_trap", {63'd0, ot}, {63'd0, ~v[0]});
                        check("R11 hw trap_el3", {63'd0, t3_hw}, 64'd0);
                        check("R11 hw other_trap", {63'd0, ot_hw}, 64'd0);
                    end
                end
            end
            @(negedge clk);
            low_valid = 1'b0; other_valid = 1'b0; el2_enable = 1'b1;
            access(2'd3, 1'b0, '0, MATCH);
            check("R9 stored enable reads back", cap_rdata, {60'd0, v[3:0]});
        end
        model = 4'hF;

        // R2 lower levels are undefined
        for (int l = 0; l < 3; l++) begin
            for (int w = 0; w < 2; w++) begin
                access(l[1:0], w[0], 64'h0, MATCH);
                check("R2 undef pulse", {63'd0, cap_undef}, 64'd1);
                check("R2 reads zero", cap_rdata, 64'd0);
                access(2'd3, 1'b0, '0, MATCH);
                check("R2 register unchanged", cap_rdata, {60'd0, model});
            end
        end
        access(2'd3, 1'b0, '0, MATCH);
        check("R2 level3 not undef", {63'd0, cap_undef}, 64'd0);

        // R1 any single-bit encoding mismatch is ignored
        for (int b = 0; b < 16; b++) begin
            access(2'd0, 1'b0, '0, MATCH ^ (16'd1 << b));
            check("R1 no undef on mismatch", {63'd0, cap_undef}, 64'd0);
            access(2'd3, 1'b1, 64'd0, MATCH ^ (16'd1 << b));
            check("R1 mismatch write no flag", {63'd0, cap_unpred}, 64'd0);
            access(2'd3, 1'b0, '0, MATCH ^ (16'd1 << b));
            check("R1 mismatch read zero", cap_rdata, 64'd0);
            access(2'd3, 1'b0, '0, MATCH);
            check("R1 register unchanged", cap_rdata, {60'd0, model});
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule